// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block loads a configuration image into a programmable target device over a two-wire serial path that the loader clocks itself. On a start strobe it pulses the target's program request low, waits for the target to release its initialisation line, and then fetches the image one byte at a time from a local byte-wide memory. Each byte goes out on the data pin least-significant bit first, one bit per rising edge of the serial clock that the loader produces. The image in memory is raw configuration bytes, with no header and no tie to any particular storage part.

Once the last image bit has been clocked, the loader keeps clocking with the data pin held at 1. This gives the target the extra edges its startup sequence needs. The loader stops when the target raises its completion line. It reports failure if the target pulls its initialisation line low while bits are still going out. It also reports failure if the completion line is still low after a programmable number of trailing clocks.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is asserted and after its release, `prog_n_o` is 1, `cclk_o` is 0, and `busy_o`, `success_o` and `error_o` are 0.
- R2: A start strobe seen while idle, passed or failed raises `busy_o` on the next clock and drives `prog_n_o` low for exactly `PROG_LOW` system clocks. No serial clock edge occurs while `prog_n_o` is low.
- R3: After the program pulse, no rising serial clock edge is produced until `init_n_i` is 1. No rising edge follows a clock in which `init_n_i` was 0.
- R4: While loading, the serial clock is high for `DIV` system clocks and low for `DIV` system clocks, so consecutive rising edges are `2*DIV` system clocks apart.
- R5: `din_o` changes only while `cclk_o` is low, so it holds the same value in the cycle before and the cycle of every rising edge.
- R6: The image bytes are sent in ascending address order starting at `base_addr_i`, with `length_i` bytes in total. Bit 0 of each byte goes first and bit 7 last, one bit per rising edge.
- R7: A memory read is a single-cycle pulse on `mem_rd_o` carrying `mem_addr_o`. The byte on `mem_data_i` is taken in the following cycle. Each image address is read exactly once, in ascending order.
- R8: After the last image bit, every rising edge carries `din_o` = 1. When `done_i` is seen high, the clock stops at 0, `busy_o` falls and `success_o` rises.
- R9: When `length_i` is 0, no memory reads are made and only trailing 1 bits are clocked until `done_i` rises.
- R10: If `done_i` stays low, exactly `extra_clk_limit_i` trailing rising edges are produced. The load then ends with `error_o` = 1 and `error_cause_o` = 1 (timeout). A `done_i` rise seen before the next edge would be due still counts as success.
- R11: If `init_n_i` is 0 while image or trailing bits are being clocked, the load ends at once with `error_o` = 1 and `error_cause_o` = 0 (target fault). No further rising edge is produced.
- R12: A start strobe while `busy_o` is 1 has no effect. Only one program pulse is issued, and the load completes exactly as if no strobe had been given.
- R13: `success_o`, `error_o` and `error_cause_o` hold their values until the next accepted start, which clears `success_o` and `error_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle strobe that begins a load |
| base_addr_i | input | AW | First memory address of the image, sampled at start |
| length_i | input | LW | Image length in bytes, sampled at start |
| extra_clk_limit_i | input | TW | Maximum number of trailing clocks, sampled at start |
| mem_rd_o | output | 1 | Memory read request pulse |
| mem_addr_o | output | AW | Memory read address |
| mem_data_i | input | 8 | Read data, valid the cycle after the request |
| prog_n_o | output | 1 | Active-low program request to the target |
| init_n_i | input | 1 | Target initialisation / fault line, active low |
| done_i | input | 1 | Target configuration-complete line |
| cclk_o | output | 1 | Serial configuration clock |
| din_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Load in progress |
| success_o | output | 1 | Last load completed with the target done |
| error_o | output | 1 | Last load failed |
| error_cause_o | output | 1 | Failure cause: 0 target fault, 1 timeout |

## Verification
The loader is driven with several image shapes. A five-byte image mixes alternating, single-set-bit, all-ones and irregular bytes, which exposes bit-order and byte-order mistakes. A one-byte image and an empty image hit the last-byte and no-prefetch paths. For the trailing-clock phase, the target's completion arrives well inside the limit, exactly at the limit, never (with a limit of four and with a limit of zero), and mid-image as a fault. These cases separate an off-by-one in the timeout count from a correct one. Further runs hold the initialisation line low for a long time and fire a second start strobe mid-load. The reference model in the bench checks every rising edge against the expected bit, its spacing and the stability of the data pin.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    LD_IDLE,
    LD_PROG,
    LD_WAIT,
    LD_SHIFT,
    LD_FLUSH,
    LD_PASS,
    LD_FAIL
  } ld_state_e;

  localparam logic CAUSE_TARGET  = 1'b0;
  localparam logic CAUSE_TIMEOUT = 1'b1;
endpackage

// File: rtl/cfg_cclk_gen.sv
module cfg_cclk_gen #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic toggle_i,
  output logic cclk_o,
  output logic edge_due_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic          cclk_d;

  assign edge_due_o = (phase_q == PH_LAST);

  always_comb begin
    phase_d = phase_q;
    cclk_d  = cclk_o;
    if (!run_i) begin
      phase_d = '0;
      cclk_d  = 1'b0;
    end else if (phase_q == PH_LAST) begin
      phase_d = '0;
      if (toggle_i) cclk_d = ~cclk_o;
    end else begin
      phase_d = phase_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cclk_o  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cclk_o  <= cclk_d;
    end
  end

  // R4
  cclk_only_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_o != $past(cclk_o)) |-> ($past(edge_due_o) || !$past(run_i)));
endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       shift_i,
  input  logic [7:0] data_i,
  output logic       din_o,
  output logic       last_o
);
  logic [7:0] sr_q, sr_d;
  logic [2:0] cnt_q, cnt_d;

  assign din_o  = sr_q[0];
  assign last_o = (cnt_q == 3'd7);

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (load_i) begin
      sr_d  = data_i;
      cnt_d = 3'd0;
    end else if (shift_i) begin
      sr_d  = {1'b1, sr_q[7:1]};
      cnt_d = cnt_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= 8'hFF;
      cnt_q <= 3'd0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  // R6
  shift_past_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> !last_o);
endmodule

// File: rtl/cfg_byte_fetch.sv
module cfg_byte_fetch #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic [AW-1:0] base_i,
  input  logic          req_i,
  input  logic          take_i,
  input  logic [7:0]    mem_data_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    hold_o,
  output logic          hold_valid_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic          rd_q, rd_d, cap_q, cap_d, valid_q, valid_d;
  logic [7:0]    hold_q, hold_d;

  assign mem_rd_o     = rd_q;
  assign mem_addr_o   = addr_q;
  assign hold_o       = hold_q;
  assign hold_valid_o = valid_q;

  always_comb begin
    addr_d  = addr_q;
    rd_d    = req_i;
    cap_d   = rd_q;
    valid_d = valid_q;
    hold_d  = hold_q;
    if (rd_q) addr_d = addr_q + AW'(1);
    if (cap_q) begin
      hold_d  = mem_data_i;
      valid_d = 1'b1;
    end
    if (take_i) valid_d = 1'b0;
    if (init_i) begin
      addr_d  = base_i;
      rd_d    = 1'b0;
      cap_d   = 1'b0;
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rd_q    <= 1'b0;
      cap_q   <= 1'b0;
      valid_q <= 1'b0;
      hold_q  <= 8'h00;
    end else begin
      addr_q  <= addr_d;
      rd_q    <= rd_d;
      cap_q   <= cap_d;
      valid_q <= valid_d;
      hold_q  <= hold_d;
    end
  end

  // R7
  rd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);
  // R7
  hold_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |-> !valid_q);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int AW       = 12,
  parameter int LW       = 12,
  parameter int TW       = 8,
  parameter int DIV      = 3,
  parameter int PROG_LOW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [LW-1:0] length_i,
  input  logic [TW-1:0] extra_clk_limit_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_data_i,
  output logic          prog_n_o,
  input  logic          init_n_i,
  input  logic          done_i,
  output logic          cclk_o,
  output logic          din_o,
  output logic          busy_o,
  output logic          success_o,
  output logic          error_o,
  output logic          error_cause_o
);
  localparam int PCW = $clog2(PROG_LOW + 1);

  ld_state_e      state_q, state_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic [LW-1:0]  left_q, left_d;
  logic [TW-1:0]  ones_q, ones_d, lim_q, lim_d;
  logic           cause_q, cause_d;

  logic fetch_init, fetch_req, fetch_take, hold_valid;
  logic [7:0] hold_byte;
  logic sh_load, sh_shift, sh_din, sh_last;
  logic active, edge_due, rise, fall, leave;

  assign active = (state_q == LD_SHIFT) || (state_q == LD_FLUSH);
  assign rise   = active && edge_due && !cclk_o;
  assign fall   = active && edge_due && cclk_o;

  cfg_cclk_gen #(.DIV(DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run_i(active), .toggle_i(active && !leave),
    .cclk_o(cclk_o), .edge_due_o(edge_due)
  );

  cfg_bit_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(sh_load), .shift_i(sh_shift),
    .data_i(hold_byte), .din_o(sh_din), .last_o(sh_last)
  );

  cfg_byte_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .init_i(fetch_init), .base_i(base_addr_i),
    .req_i(fetch_req), .take_i(fetch_take), .mem_data_i(mem_data_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .hold_o(hold_byte),
    .hold_valid_o(hold_valid)
  );

  always_comb begin
    state_d    = state_q;
    pcnt_d     = pcnt_q;
    left_d     = left_q;
    ones_d     = ones_q;
    lim_d      = lim_q;
    cause_d    = cause_q;
    fetch_init = 1'b0;
    fetch_req  = 1'b0;
    fetch_take = 1'b0;
    sh_load    = 1'b0;
    sh_shift   = 1'b0;
    leave      = 1'b0;
    unique case (state_q)
      LD_IDLE, LD_PASS, LD_FAIL: begin
        if (start_i) begin
          state_d    = LD_PROG;
          pcnt_d     = '0;
          left_d     = length_i;
          lim_d      = extra_clk_limit_i;
          ones_d     = '0;
          fetch_init = 1'b1;
        end
      end
      LD_PROG: begin
        pcnt_d = pcnt_q + PCW'(1);
        if (pcnt_q == PCW'(PROG_LOW - 1)) begin
          state_d   = LD_WAIT;
          fetch_req = (left_q != '0);
        end
      end
      LD_WAIT: begin
        if (init_n_i) begin
          if (left_q == '0) begin
            state_d = LD_FLUSH;
          end else if (hold_valid) begin
            state_d    = LD_SHIFT;
            sh_load    = 1'b1;
            fetch_take = 1'b1;
            fetch_req  = (left_q > LW'(1));
          end
        end
      end
      LD_SHIFT: begin
        if (!init_n_i) begin
          state_d = LD_FAIL;
          cause_d = CAUSE_TARGET;
          leave   = 1'b1;
        end else if (fall) begin
          if (!sh_last) begin
            sh_shift = 1'b1;
          end else if (left_q == LW'(1)) begin
            state_d = LD_FLUSH;
            left_d  = '0;
          end else begin
            sh_load    = 1'b1;
            fetch_take = 1'b1;
            left_d     = left_q - LW'(1);
            fetch_req  = (left_q > LW'(2));
          end
        end
      end
      LD_FLUSH: begin
        if (done_i) begin
          state_d = LD_PASS;
          leave   = 1'b1;
        end else if (!init_n_i) begin
          state_d = LD_FAIL;
          cause_d = CAUSE_TARGET;
          leave   = 1'b1;
        end else if (rise) begin
          if (ones_q == lim_q) begin
            state_d = LD_FAIL;
            cause_d = CAUSE_TIMEOUT;
            leave   = 1'b1;
          end else begin
            ones_d = ones_q + TW'(1);
          end
        end
      end
      default: state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      pcnt_q  <= '0;
      left_q  <= '0;
      ones_q  <= '0;
      lim_q   <= '0;
      cause_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
      left_q  <= left_d;
      ones_q  <= ones_d;
      lim_q   <= lim_d;
      cause_q <= cause_d;
    end
  end

  assign prog_n_o      = (state_q != LD_PROG);
  assign busy_o        = !((state_q == LD_IDLE) || (state_q == LD_PASS) || (state_q == LD_FAIL));
  assign success_o     = (state_q == LD_PASS);
  assign error_o       = (state_q == LD_FAIL);
  assign error_cause_o = cause_q;
  assign din_o         = (state_q == LD_SHIFT) ? sh_din : 1'b1;

  // R5
  din_stable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(din_o));
  // R3
  no_rise_init_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $past(init_n_i));
  // R2
  prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> (!cclk_o && busy_o));
  // R8
  end_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (success_o ^ error_o));
  // R10
  ones_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LD_FLUSH) |-> (ones_q <= lim_q));
  // R12
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && state_q != LD_PROG) |=> (state_q != LD_PROG));
endmodule

// File: tb/cfg_serial_loader_tb_top.sv
module cfg_serial_loader_tb_top;
  localparam int AW = 12, LW = 12, TW = 8, DIV = 3, PROG_LOW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [AW-1:0] base_addr_i;
  logic [LW-1:0] length_i;
  logic [TW-1:0] extra_clk_limit_i;
  logic mem_rd_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0] mem_data_i;
  logic prog_n_o, init_n_i, done_i, cclk_o, din_o;
  logic busy_o, success_o, error_o, error_cause_o;

  always #2 clk = ~clk;

  cfg_serial_loader #(.AW(AW), .LW(LW), .TW(TW), .DIV(DIV), .PROG_LOW(PROG_LOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .length_i(length_i), .extra_clk_limit_i(extra_clk_limit_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .prog_n_o(prog_n_o), .init_n_i(init_n_i), .done_i(done_i),
    .cclk_o(cclk_o), .din_o(din_o), .busy_o(busy_o), .success_o(success_o),
    .error_o(error_o), .error_cause_o(error_cause_o)
  );

  int checks = 0, errors = 0;
  logic [7:0] mem [0:255];
  bit exp_bits[$];
  int exp_total = 0, base_cfg = 0;
  int init_delay = 0, done_after = -1, abort_after = -1;
  int bits_seen = 0, ones_seen = 0, reads_seen = 0, prog_pulses = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Target and memory reference model, evaluated every clock
  initial begin
    int cyc = 0, last_rise = -1, high_start = 0, prog_low_cnt = 0, since_prog = 0;
    bit pc = 1'b0, pd = 1'b1, pp = 1'b1, released = 1'b0, aborted = 1'b0;
    init_n_i = 1'b1; done_i = 1'b0; mem_data_i = 8'h00;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n !== 1'b1) begin
        init_n_i = 1'b1; done_i = 1'b0; pc = 1'b0; pd = 1'b1; pp = 1'b1;
        continue;
      end
      if (!prog_n_o) begin
        if (pp) begin prog_pulses++; prog_low_cnt = 0; end
        prog_low_cnt++;
        init_n_i = 1'b0; done_i = 1'b0;
        bits_seen = 0; ones_seen = 0; reads_seen = 0; last_rise = -1;
        since_prog = 0; released = 1'b0; aborted = 1'b0;
      end else begin
        if (!pp) chk(prog_low_cnt == PROG_LOW, "R2", "program pulse length", prog_low_cnt, PROG_LOW);
        if (!released && !aborted && prog_pulses > 0) begin
          if (since_prog >= init_delay) begin init_n_i = 1'b1; released = 1'b1; end
          since_prog++;
        end
      end
      if (mem_rd_o) begin
        chk(int'(mem_addr_o) == base_cfg + reads_seen, "R7", "read address", int'(mem_addr_o), base_cfg + reads_seen);
        reads_seen++;
        mem_data_i = mem[mem_addr_o[7:0]];
      end
      if (cclk_o && !pc) begin
        chk(busy_o, "R8", "rise while idle", busy_o, 1);
        chk(init_n_i, "R3", "rise with init low", init_n_i, 1);
        chk(din_o == pd, "R5", "din moved at rise", din_o, pd);
        if (last_rise >= 0) chk(cyc - last_rise == 2 * DIV, "R4", "rise spacing", cyc - last_rise, 2 * DIV);
        last_rise = cyc; high_start = cyc;
        if (bits_seen < exp_total) begin
          chk(din_o == exp_bits[bits_seen], "R6", "image bit", din_o, exp_bits[bits_seen]);
          bits_seen++;
          if (bits_seen == abort_after) begin init_n_i = 1'b0; aborted = 1'b1; end
        end else begin
          chk(din_o == 1'b1, "R8", "trailing bit", din_o, 1);
          ones_seen++;
          if (ones_seen == done_after) done_i = 1'b1;
        end
      end
      if (!cclk_o && pc && busy_o) chk(cyc - high_start == DIV, "R4", "high time", cyc - high_start, DIV);
      pc = cclk_o; pd = din_o; pp = prog_n_o;
    end
  end

  task automatic run_case(input string req, input int base, input int len, input int lim,
                          input int idly, input int dafter, input int aafter, input int restart_at,
                          input bit exp_pass, input bit exp_cause, input int exp_b,
                          input int exp_ones, input int exp_reads);
    int n;
    exp_bits.delete();
    for (int b = 0; b < len; b++)
      for (int k = 0; k < 8; k++) exp_bits.push_back(mem[(base + b) & 255][k]);
    exp_total = len * 8; base_cfg = base;
    init_delay = idly; done_after = dafter; abort_after = aafter;
    @(negedge clk);
    prog_pulses = 0;
    base_addr_i = AW'(base); length_i = LW'(len); extra_clk_limit_i = TW'(lim);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !success_o && !error_o, "R13", "status cleared on start", {busy_o, success_o, error_o}, 3'b100);
    if (restart_at > 0) begin
      repeat (restart_at) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    n = 0;
    while (busy_o && n < 20000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk(success_o == exp_pass && error_o == !exp_pass, req, "outcome", {success_o, error_o}, {exp_pass, !exp_pass});
    if (!exp_pass) chk(error_cause_o == exp_cause, req, "cause", error_cause_o, exp_cause);
    chk(bits_seen == exp_b, req, "image bits clocked", bits_seen, exp_b);
    chk(ones_seen == exp_ones, req, "trailing clocks", ones_seen, exp_ones);
    chk(reads_seen == exp_reads, req, "memory reads", reads_seen, exp_reads);
    chk(!cclk_o && prog_n_o, req, "pins at rest", {cclk_o, prog_n_o}, 2'b01);
    chk(prog_pulses == 1, "R12", "program pulses", prog_pulses, 1);
    chk(success_o == exp_pass && !busy_o, "R13", "status held", success_o, exp_pass);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 53 + 7) & 255);
    mem[16] = 8'hA5; mem[17] = 8'h01; mem[18] = 8'h80; mem[19] = 8'hFF; mem[20] = 8'h3C;
    rst_n = 1'b0; start_i = 1'b0; base_addr_i = '0; length_i = '0; extra_clk_limit_i = '0;
    repeat (3) @(negedge clk);
    chk(prog_n_o && !cclk_o && !busy_o && !success_o && !error_o, "R1", "reset state",
        {prog_n_o, cclk_o, busy_o, success_o, error_o}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prog_n_o && !cclk_o && !busy_o && !success_o && !error_o, "R1", "after release",
        {prog_n_o, cclk_o, busy_o, success_o, error_o}, 5'b10000);
    // R6 R8: mixed five-byte image, done after three trailing clocks
    run_case("R6", 16, 5, 8, 2, 3, -1, 0, 1'b1, 1'b0, 40, 3, 5);
    // R8: single byte, done after one trailing clock
    run_case("R8", 40, 1, 8, 0, 1, -1, 0, 1'b1, 1'b0, 8, 1, 1);
    // R9: empty image
    run_case("R9", 60, 0, 5, 1, 2, -1, 0, 1'b1, 1'b0, 0, 2, 0);
    // R10: timeout after four trailing clocks
    run_case("R10", 70, 2, 4, 1, -1, -1, 0, 1'b0, 1'b1, 16, 4, 2);
    // R10: zero limit
    run_case("R10", 80, 1, 0, 1, -1, -1, 0, 1'b0, 1'b1, 8, 0, 1);
    // R10: done exactly at the limit still passes
    run_case("R10", 90, 2, 4, 1, 4, -1, 0, 1'b1, 1'b0, 16, 4, 2);
    // R11: target fault after 13 image bits
    run_case("R11", 100, 4, 8, 1, -1, 13, 0, 1'b0, 1'b0, 13, 0, 3);
    // R12: second start mid-load is ignored
    run_case("R12", 120, 3, 8, 1, 2, -1, 20, 1'b1, 1'b0, 24, 2, 3);
    // R3: long initialisation wait
    run_case("R3", 130, 2, 8, 30, 1, -1, 0, 1'b1, 1'b0, 16, 1, 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule